// File: doc/BRIEF.md
# Phase-Frequency Detector with Polarity Select and Lock Indicator

This block sits between the reference divider and the feedback divider of a frequency synthesizer. It watches two divided pulse trains: the reference pulse and the feedback pulse. From the order and spacing of their rising edges it produces the control for an external charge pump. That control is a three-state output, modelled as a drive enable plus a drive level. There is also a push-pull comparator output and an open-drain comparator output, modelled as a pull-low request. Everything runs on the oscillator clock, and both pulse inputs are treated as synchronous to it.

A polarity input reverses the sense of every comparator output. This suits loop filters and oscillators whose tuning slope runs the other way. The same input selects which of the two pulse trains is copied to a monitor output. A lock indicator measures each error pulse in oscillator cycles. It drops as soon as a pulse reaches the unlock width. It rises again only after a run of consecutive comparisons with small errors.

Top module: `pfd_lock_top`

## Requirements
- R1: After synchronous reset the charge-pump enable, push-pull output, pull-low request and monitor are all 0, and the lock indicator is low (unlocked).
- R2: With polarity 1 and the reference edge ahead of the feedback edge, the charge-pump output drives high (enable 1, level 1). In the same cycles the push-pull output is 0 and the pull-low request is 1.
- R3: With polarity 1 and the reference edge behind the feedback edge, the charge-pump output drives low (enable 1, level 0). In the same cycles the push-pull output is 1 and the pull-low request is 0.
- R4: When both rising edges arrive in the same clock cycle, the enable stays 0, the push-pull output stays 0 and the pull-low request stays 0, whatever the polarity.
- R5: With polarity 0, the lead case produces the R3 output pattern and the lag case produces the R2 output pattern.
- R6: The monitor output is a one-cycle-delayed copy of the reference input when polarity is 1, and of the feedback input when polarity is 0.
- R7: The first rising edge sets the up or down state. The second edge sets the other one. Both are cleared one cycle after both are set. As a result, each error output stays active for exactly as many clock cycles as the two edges are apart, up to a full comparison period.
- R8: An error pulse of UNLOCK_W (default 8) cycles or more drives the lock indicator low. A pulse of UNLOCK_W-1 cycles leaves it unchanged.
- R9: The lock indicator rises only after RELOCK_N (default 3) consecutive comparisons whose error stayed below UNLOCK_W and at or below LOCK_W (default 16). Any comparison that trips the unlock restarts this count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_i | input | 1 | Polarity: 1 normal sense, 0 reversed |
| fr_i | input | 1 | Reference divider pulse |
| fp_i | input | 1 | Feedback divider pulse |
| do_en_o | output | 1 | Charge-pump drive enable (0 = high impedance) |
| do_lvl_o | output | 1 | Charge-pump drive level when enabled |
| phr_o | output | 1 | Push-pull comparator output |
| php_pull_o | output | 1 | Open-drain comparator output: 1 pulls low, 0 released |
| mon_o | output | 1 | Monitor copy of the selected pulse |
| ld_o | output | 1 | Lock indicator, 1 = locked |

## Verification
The bench sweeps edge offsets of both signs and zero under both polarities, and counts active cycles per output. A detector that mapped lead and lag the wrong way, or ignored polarity, would swap the up and down counts. One that missed the clear step would hold an output for the whole period. The unlock boundary is probed at 7 and 8 cycles: an off-by-one in the width counter would drop lock one pulse early or late. Relock is driven with runs of small errors after an unlock. A detector that did not restart its count, or that relocked after two good comparisons, shows the indicator high too soon.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_LEAD = 2'd1,
    ERR_LAG  = 2'd2
  } err_e;
endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fr_in,
  input  logic fp_in,
  output logic up_q,
  output logic dn_q,
  output err_e state
);
  logic fr_d, fp_d;
  logic fr_rise, fp_rise;

  assign fr_rise = fr_in & ~fr_d;
  assign fp_rise = fp_in & ~fp_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_d <= 1'b0;
      fp_d <= 1'b0;
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      fr_d <= fr_in;
      fp_d <= fp_in;
      if (up_q && dn_q) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else begin
        up_q <= up_q | fr_rise;
        dn_q <= dn_q | fp_rise;
      end
    end
  end

  always_comb begin
    if (up_q && !dn_q)      state = ERR_LEAD;
    else if (dn_q && !up_q) state = ERR_LAG;
    else                    state = ERR_NONE;
  end
endmodule

// File: rtl/pfd_out_map.sv
module pfd_out_map
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pol,
  input  logic fr_in,
  input  logic fp_in,
  input  err_e state,
  output logic do_en,
  output logic do_lvl,
  output logic phr,
  output logic php_pull,
  output logic mon
);
  err_e eff;

  always_comb begin
    eff = state;
    if (!pol) begin
      case (state)
        ERR_LEAD: eff = ERR_LAG;
        ERR_LAG:  eff = ERR_LEAD;
        default:  eff = ERR_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      do_en    <= 1'b0;
      do_lvl   <= 1'b0;
      phr      <= 1'b0;
      php_pull <= 1'b0;
      mon      <= 1'b0;
    end else begin
      mon <= pol ? fr_in : fp_in;
      case (eff)
        ERR_LEAD: begin
          do_en <= 1'b1; do_lvl <= 1'b1; phr <= 1'b0; php_pull <= 1'b1;
        end
        ERR_LAG: begin
          do_en <= 1'b1; do_lvl <= 1'b0; phr <= 1'b1; php_pull <= 1'b0;
        end
        default: begin
          do_en <= 1'b0; do_lvl <= 1'b0; phr <= 1'b0; php_pull <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int UNLOCK_W = 8,
  parameter int LOCK_W   = 16,
  parameter int RELOCK_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic err,
  input  logic clr,
  output logic ld
);
  localparam int WMAX  = (UNLOCK_W > LOCK_W) ? UNLOCK_W : LOCK_W;
  localparam int CNT_W = $clog2(WMAX + 2);
  localparam int GD_W  = $clog2(RELOCK_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TRIP_C   = CNT_W'(UNLOCK_W - 1);
  localparam logic [CNT_W-1:0] LOCK_C   = CNT_W'(LOCK_W);
  localparam logic [GD_W-1:0]  RELOCK_C = GD_W'(RELOCK_N);

  logic [CNT_W-1:0] width_q;
  logic [GD_W-1:0]  good_q;
  logic             tripped_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q   <= '0;
      good_q    <= '0;
      tripped_q <= 1'b0;
      ld        <= 1'b0;
    end else if (clr) begin
      width_q   <= '0;
      tripped_q <= 1'b0;
      if (!tripped_q && width_q <= LOCK_C) begin
        if (good_q >= RELOCK_C - 1'b1) begin
          good_q <= RELOCK_C;
          ld     <= 1'b1;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        good_q <= '0;
      end
    end else if (err) begin
      if (width_q != CNT_MAX) width_q <= width_q + 1'b1;
      if (width_q >= TRIP_C) begin
        ld        <= 1'b0;
        good_q    <= '0;
        tripped_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int UNLOCK_W = 8,
  parameter int LOCK_W   = 16,
  parameter int RELOCK_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pol_i,
  input  logic fr_i,
  input  logic fp_i,
  output logic do_en_o,
  output logic do_lvl_o,
  output logic phr_o,
  output logic php_pull_o,
  output logic mon_o,
  output logic ld_o
);
  logic up_w, dn_w;
  err_e state_w;

  pfd_edge_core u_core (
    .clk(clk), .rst(rst), .fr_in(fr_i), .fp_in(fp_i),
    .up_q(up_w), .dn_q(dn_w), .state(state_w)
  );

  pfd_out_map u_map (
    .clk(clk), .rst(rst), .pol(pol_i), .fr_in(fr_i), .fp_in(fp_i),
    .state(state_w), .do_en(do_en_o), .do_lvl(do_lvl_o), .phr(phr_o),
    .php_pull(php_pull_o), .mon(mon_o)
  );

  pfd_lock_det #(.UNLOCK_W(UNLOCK_W), .LOCK_W(LOCK_W), .RELOCK_N(RELOCK_N)) u_lock (
    .clk(clk), .rst(rst), .err(up_w ^ dn_w), .clr(up_w & dn_w), .ld(ld_o)
  );
endmodule

// File: rtl/pfd_lock_sva.sv
module pfd_lock_sva (
  input logic clk,
  input logic rst,
  input logic up,
  input logic dn,
  input logic do_en,
  input logic phr,
  input logic php,
  input logic ld
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!ld && !do_en && !phr && !php));
  // R7
  a_r7_clear_after_both: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> (!up && !dn));
  // R3
  a_r3_phr_with_drive: assert property (@(posedge clk) disable iff (rst)
    phr |-> do_en);
  // R2
  a_r2_php_excludes_phr: assert property (@(posedge clk) disable iff (rst)
    !(php && phr));
  // R8
  a_r8_unlock_on_error: assert property (@(posedge clk) disable iff (rst)
    $fell(ld) |-> $past(up ^ dn));
  // R9
  a_r9_lock_on_compare: assert property (@(posedge clk) disable iff (rst)
    $rose(ld) |-> $past(up && dn));
endmodule

bind pfd_lock_top pfd_lock_sva u_sva (
  .clk(clk), .rst(rst), .up(up_w), .dn(dn_w), .do_en(do_en_o),
  .phr(phr_o), .php(php_pull_o), .ld(ld_o)
);

// File: tb/pfd_lock_top_bench.sv
`timescale 1ns/1ps
module pfd_lock_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pol = 1'b1;
  logic fr = 1'b0;
  logic fp = 1'b0;
  logic do_en, do_lvl, phr, php, mon, ld;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfd_lock_top u_pfd_lock_top (
    .clk(clk), .rst(rst), .pol_i(pol), .fr_i(fr), .fp_i(fp),
    .do_en_o(do_en), .do_lvl_o(do_lvl), .phr_o(phr), .php_pull_o(php),
    .mon_o(mon), .ld_o(ld)
  );

  typedef struct {
    int    up, dn, phr, php, mon;
    bit    ld;
    int    len;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  localparam int WIN = 40;
  int  m_good = 0;
  bit  m_ld   = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: k > 0 means reference edge leads by k cycles
  task automatic win(input bit p, input int k, input string tag);
    exp_t e;
    int tf, tp, ak;
    bit lead;
    ak = (k < 0) ? -k : k;
    tf = (k >= 0) ? 2 : 2 - k;
    tp = (k >= 0) ? 2 + k : 2;
    lead = (k > 0) ? p : !p;
    e.up  = (k != 0 && lead)  ? ak : 0;
    e.dn  = (k != 0 && !lead) ? ak : 0;
    e.php = e.up;
    e.phr = e.dn;
    e.mon = p ? 2 : 1;
    if (ak >= 8) begin
      m_good = 0; m_ld = 1'b0;
    end else begin
      if (m_good < 3) m_good++;
      if (m_good == 3) m_ld = 1'b1;
    end
    e.ld = m_ld;
    e.len = WIN;
    e.tag = tag;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (i == 0) sb_q.push_back(e);
      pol = p;
      fr = (i == tf) || (i == tf + 1);
      fp = (i == tp);
    end
  endtask

  // monitor
  int a_up = 0, a_dn = 0, a_phr = 0, a_php = 0, a_mon = 0, wcnt = 0;
  always @(negedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      a_up  += int'(do_en & do_lvl);
      a_dn  += int'(do_en & ~do_lvl);
      a_phr += int'(phr);
      a_php += int'(php);
      a_mon += int'(mon);
      wcnt++;
      if (wcnt == sb_q[0].len) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " up drive"}, a_up, e.up);
        check({e.tag, " down drive"}, a_dn, e.dn);
        check({e.tag, " push-pull"}, a_phr, e.phr);
        check({e.tag, " pull-low"}, a_php, e.php);
        check({e.tag, " R6 monitor"}, a_mon, e.mon);
        check({e.tag, " lock"}, int'(ld), int'(e.ld));
        a_up = 0; a_dn = 0; a_phr = 0; a_php = 0; a_mon = 0; wcnt = 0;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 ld", int'(ld), 0);
    check("R1 do_en", int'(do_en), 0);
    check("R1 phr", int'(phr), 0);
    check("R1 php", int'(php), 0);
    check("R1 mon", int'(mon), 0);
    rst = 1'b0;
    win(1'b1,  3, "R2 R7 R9 lead pol1");
    win(1'b1, -4, "R3 R7 R9 lag pol1");
    win(1'b1,  0, "R4 R9 aligned pol1 lock");
    win(1'b0,  3, "R5 lead pol0");
    win(1'b0, -4, "R5 lag pol0");
    win(1'b0,  0, "R4 R5 aligned pol0");
    win(1'b1,  7, "R8 width7 keeps lock");
    win(1'b1,  8, "R8 width8 unlocks");
    win(1'b0, -2, "R9 relock 1");
    win(1'b1,  2, "R9 relock 2");
    win(1'b1, 10, "R8 R9 unlock restarts");
    win(1'b1,  1, "R9 relock a");
    win(1'b1, -1, "R9 relock b");
    win(1'b1,  1, "R9 relock c");
    win(1'b1, -20, "R7 R8 long lag");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule